// File: doc/BRIEF.md
# Single-Address Dual-FIFO Bus Target

This block places two independent one-way FIFOs behind a single 32-bit register address of a simplified PCI-style target handshake. The direction of the bus cycle picks the FIFO: a read cycle takes the oldest word from the outbound FIFO, which the add-on logic fills. A write cycle places a word into the inbound FIFO, which the add-on logic drains. Because a write and a read reach different storage, a host can never read back a word it has just written.

Each access to the address completes at most one data phase. When the target transfers a word, it raises STOP together with TRDY, so a burst is always cut after its first phase. This keeps an initiator from resuming the burst at an incremented address that no longer points at the FIFO. When the selected FIFO cannot take part, either because a read finds it empty or a write finds it full, the target answers at once with a retry: STOP without TRDY. No data moves and no state changes. The add-on side uses plain valid/ready strobes. Registered empty and full flags for both FIFOs trail the access that changed them by one clock.

Top module: `fifo_port_target`

## Requirements
- R1: A read data phase (address phase with `cmd_write`=0) while the outbound FIFO holds data drives `trdy_n`=0 and `stop_n`=0 in the same cycle, and puts the oldest outbound word on `ad_out`. That word is removed.
- R2: A read data phase while the outbound FIFO is empty drives `stop_n`=0 with `trdy_n`=1. No word is removed and the outbound flags stay unchanged.
- R3: A write data phase (address phase with `cmd_write`=1) while the inbound FIFO has room drives `trdy_n`=0 and `stop_n`=0, and stores `ad_in`. The add-on side receives the stored words in write order on `ib_rdata`.
- R4: A write data phase while the inbound FIFO holds `FIFO_DEPTH` words drives `stop_n`=0 with `trdy_n`=1. Nothing is stored.
- R5: An access completes at most one data phase. If the initiator keeps `frame_n` low after a transfer, `trdy_n` stays high and `stop_n` stays low.
- R6: A read never returns a word written by the host. It returns outbound data, or it is retried when the outbound FIFO is empty.
- R7: `ob_empty`, `ob_full`, `ib_empty` and `ib_full` change one clock after the edge at which the FIFO occupancy changed, not at that edge.
- R8: After STOP is asserted, `stop_n` and `devsel_n` stay low until `frame_n` is sampled high. At the next edge both return high.
- R9: A host push and an add-on pop on the inbound FIFO in the same cycle leave its occupancy unchanged.
- R10: After reset, `trdy_n`, `stop_n` and `devsel_n` are 1, both empty flags are 1 and both full flags are 0.
- R11: An address phase with `hit`=0 draws no response: `devsel_n`, `trdy_n` and `stop_n` stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| hit | input | 1 | Address decode hit for the FIFO address, sampled in the address phase |
| cmd_write | input | 1 | Direction in the address phase: 1 = write, 0 = read |
| ad_in | input | 32 | Write data from the initiator |
| ad_out | output | 32 | Read data, valid while `trdy_n` is low on a read |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| devsel_n | output | 1 | Device select, active low |
| ob_wdata | input | 32 | Add-on word for the outbound FIFO |
| ob_wvalid | input | 1 | Add-on push request |
| ob_wready | output | 1 | Outbound FIFO has room |
| ib_rdata | output | 32 | Oldest inbound word |
| ib_rvalid | output | 1 | Inbound FIFO holds data |
| ib_rready | input | 1 | Add-on pop request |
| ob_empty | output | 1 | Registered outbound empty flag |
| ob_full | output | 1 | Registered outbound full flag |
| ib_empty | output | 1 | Registered inbound empty flag |
| ib_full | output | 1 | Registered inbound full flag |

## Verification
The assertions check on every cycle that no FIFO is pushed past full or popped when empty, and that a push with a pop in the same cycle keeps the occupancy. They also check that TRDY never lasts two cycles, that TRDY always comes with STOP, that an empty read is never given TRDY, that STOP and DEVSEL are held until FRAME is released, and that a full flag only follows the occupancy one clock later. Word ordering, the exact words returned to the host and to the add-on side, the absence of read-back, and the proof that a retried access leaves the contents intact can only be shown by the bench's scenarios. These scenarios fill, drain and compare the FIFOs through the ports.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
   typedef enum logic [1:0] {
      TS_IDLE    = 2'd0,
      TS_DATA    = 2'd1,
      TS_BACKOFF = 2'd2
   } tgt_state_e;
endpackage

// File: rtl/fpt_fifo.sv
module fpt_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          room,
   output logic          avail,
   output logic          empty_q,
   output logic          full_q
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fpt_fifo: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("fpt_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign room  = (count != CNT_FULL);
   assign avail = (count != '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         empty_q <= 1'b1;
         full_q  <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         empty_q <= (count == '0);
         full_q  <= (count == CNT_FULL);
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_FULL));
   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
   a_r9_pushpop_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> (count == $past(count)));
   a_r7_full_lags: assert property (@(posedge clk) disable iff (!rst_n)
      ((count == CNT_FULL) && !full_q) |=> full_q);
   a_r7_empty_lags: assert property (@(posedge clk) disable iff (!rst_n)
      ((count == '0) && !empty_q) |=> empty_q);
endmodule

// File: rtl/fpt_target_fsm.sv
module fpt_target_fsm
   import fpt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   input  logic hit,
   input  logic cmd_write,
   input  logic ob_avail,
   input  logic ib_room,
   output logic trdy_n,
   output logic stop_n,
   output logic devsel_n,
   output logic pop_ob,
   output logic push_ib
);
   tgt_state_e state, state_nxt;
   logic       dir_wr_q;
   logic       phase, can_serve;

   assign phase     = (state == TS_DATA) && !irdy_n;
   assign can_serve = dir_wr_q ? ib_room : ob_avail;

   always_comb begin
      state_nxt = state;
      case (state)
         TS_IDLE:    if (!frame_n && hit) state_nxt = TS_DATA;
         TS_DATA:    if (!irdy_n)         state_nxt = TS_BACKOFF;
         TS_BACKOFF: if (frame_n)         state_nxt = TS_IDLE;
         default:                         state_nxt = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= TS_IDLE;
         dir_wr_q <= 1'b0;
      end else begin
         state <= state_nxt;
         if (state == TS_IDLE && !frame_n && hit) dir_wr_q <= cmd_write;
      end
   end

   assign devsel_n = (state == TS_IDLE);
   assign trdy_n   = !(phase && can_serve);
   assign stop_n   = !(phase || state == TS_BACKOFF);
   assign pop_ob   = phase && can_serve && !dir_wr_q;
   assign push_ib  = phase && can_serve && dir_wr_q;

   a_r5_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |=> trdy_n);
   a_r5_trdy_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> !stop_n);
   a_r2_empty_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_n && !irdy_n && !dir_wr_q && !ob_avail) |-> trdy_n);
   a_r8_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n && !frame_n) |=> (!stop_n && !devsel_n));
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n && trdy_n && frame_n && irdy_n) |=> (stop_n && devsel_n));
   a_r11_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
      (devsel_n && !hit) |=> devsel_n);
endmodule

// File: rtl/fifo_port_target.sv
module fifo_port_target #(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              hit,
   input  logic              cmd_write,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              trdy_n,
   output logic              stop_n,
   output logic              devsel_n,
   input  logic [DATA_W-1:0] ob_wdata,
   input  logic              ob_wvalid,
   output logic              ob_wready,
   output logic [DATA_W-1:0] ib_rdata,
   output logic              ib_rvalid,
   input  logic              ib_rready,
   output logic              ob_empty,
   output logic              ob_full,
   output logic              ib_empty,
   output logic              ib_full
);
   if (DATA_W != 32) begin : g_bad_bus
      $error("fifo_port_target: the register location is 32 bits wide");
   end

   logic ob_avail, ob_room, ib_avail, ib_room;
   logic pop_ob, push_ib;
   logic [DATA_W-1:0] ob_head;

   fpt_target_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .hit       (hit),
      .cmd_write (cmd_write),
      .ob_avail  (ob_avail),
      .ib_room   (ib_room),
      .trdy_n    (trdy_n),
      .stop_n    (stop_n),
      .devsel_n  (devsel_n),
      .pop_ob    (pop_ob),
      .push_ib   (push_ib)
   );

   fpt_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_outbound (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (ob_wvalid && ob_room),
      .din     (ob_wdata),
      .pop     (pop_ob),
      .dout    (ob_head),
      .room    (ob_room),
      .avail   (ob_avail),
      .empty_q (ob_empty),
      .full_q  (ob_full)
   );

   fpt_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_inbound (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_ib),
      .din     (ad_in),
      .pop     (ib_rready && ib_avail),
      .dout    (ib_rdata),
      .room    (ib_room),
      .avail   (ib_avail),
      .empty_q (ib_empty),
      .full_q  (ib_full)
   );

   assign ad_out    = pop_ob ? ob_head : '0;
   assign ob_wready = ob_room;
   assign ib_rvalid = ib_avail;

   a_r6_read_not_inbound: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_ob && push_ib));
endmodule

// File: tb/fifo_port_target_test.sv
module fifo_port_target_test;
   localparam int DEPTH = 4;

   logic        clk = 0, rst_n = 0;
   logic        frame_n = 1, irdy_n = 1, hit = 0, cmd_write = 0;
   logic [31:0] ad_in = '0, ad_out;
   logic        trdy_n, stop_n, devsel_n;
   logic [31:0] ob_wdata = '0, ib_rdata;
   logic        ob_wvalid = 0, ob_wready, ib_rvalid, ib_rready = 0;
   logic        ob_empty, ob_full, ib_empty, ib_full;

   int compared = 0, mismatched = 0;
   logic        g_trdy, g_stop, bo_ib_empty, bo_ob_empty;
   logic [31:0] g_data;

   always #10 clk = ~clk;

   fifo_port_target #(.DATA_W(32), .FIFO_DEPTH(DEPTH)) uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one address phase plus one data phase; burst keeps frame_n low
   task automatic bus_access(input logic is_wr, input logic [31:0] wd,
                             input logic burst, input logic pop_ib);
      @(negedge clk);
      frame_n = 0; hit = 1; cmd_write = is_wr; ad_in = wd; irdy_n = 1;
      @(negedge clk);
      hit = 0; irdy_n = 0; frame_n = burst ? 1'b0 : 1'b1; ib_rready = pop_ib;
      #1;
      g_trdy = trdy_n; g_stop = stop_n; g_data = ad_out;
      @(negedge clk);
      ib_rready = 0;
      bo_ib_empty = ib_empty; bo_ob_empty = ob_empty;
      if (burst) begin
         chk("R5 trdy after burst phase", {31'd0, trdy_n}, 32'd1);
         chk("R8 stop held while frame low", {31'd0, stop_n}, 32'd0);
         chk("R8 devsel held while frame low", {31'd0, devsel_n}, 32'd0);
         frame_n = 1;
         @(negedge clk);
      end else begin
         chk("R8 stop held in backoff", {31'd0, stop_n}, 32'd0);
      end
      irdy_n = 1;
      @(negedge clk);
      chk("R8 devsel released", {31'd0, devsel_n}, 32'd1);
      chk("R8 stop released", {31'd0, stop_n}, 32'd1);
   endtask

   task automatic addon_push(input logic [31:0] d);
      @(negedge clk);
      ob_wdata = d; ob_wvalid = 1;
      @(negedge clk);
      ob_wvalid = 0;
   endtask

   task automatic addon_pop(input string req, input logic [31:0] exp);
      @(negedge clk);
      chk({req, " valid"}, {31'd0, ib_rvalid}, 32'd1);
      chk({req, " data"}, ib_rdata, exp);
      ib_rready = 1;
      @(negedge clk);
      ib_rready = 0;
   endtask

   task automatic t_reset;
      chk("R10 trdy_n", {31'd0, trdy_n}, 32'd1);
      chk("R10 stop_n", {31'd0, stop_n}, 32'd1);
      chk("R10 devsel_n", {31'd0, devsel_n}, 32'd1);
      chk("R10 flags", {28'd0, ob_empty, ob_full, ib_empty, ib_full}, 32'b1010);
   endtask

   task automatic t_no_hit;
      @(negedge clk);
      frame_n = 0; hit = 0; cmd_write = 0;
      repeat (3) begin
         @(negedge clk);
         irdy_n = 0;
         chk("R11 devsel_n", {31'd0, devsel_n}, 32'd1);
         chk("R11 stop/trdy", {30'd0, stop_n, trdy_n}, 32'd3);
      end
      frame_n = 1; irdy_n = 1;
   endtask

   task automatic t_empty_read;
      bus_access(0, 32'h0, 0, 0);
      chk("R2 trdy_n on empty read", {31'd0, g_trdy}, 32'd1);
      chk("R2 stop_n on empty read", {31'd0, g_stop}, 32'd0);
      chk("R2 ob_empty kept", {31'd0, ob_empty}, 32'd1);
   endtask

   task automatic t_write_order;
      bus_access(1, 32'hA000_0001, 0, 0);
      chk("R3 trdy_n on write", {31'd0, g_trdy}, 32'd0);
      chk("R3 stop_n with data", {31'd0, g_stop}, 32'd0);
      chk("R7 ib_empty lags one clock", {31'd0, bo_ib_empty}, 32'd1);
      chk("R7 ib_empty follows", {31'd0, ib_empty}, 32'd0);
      bus_access(1, 32'hA000_0002, 1, 0);
      chk("R5 burst first phase done", {31'd0, g_trdy}, 32'd0);
      // R6: inbound holds data, outbound empty -> read is retried
      bus_access(0, 32'h0, 0, 0);
      chk("R6 no read-back", {31'd0, g_trdy}, 32'd1);
      addon_pop("R3 first word", 32'hA000_0001);
      addon_pop("R3 second word", 32'hA000_0002);
      @(negedge clk);
      chk("R3 drained", {31'd0, ib_rvalid}, 32'd0);
   endtask

   task automatic t_full_write;
      for (int i = 0; i < DEPTH; i++) bus_access(1, 32'hB000_0000 + i, 0, 0);
      chk("R7 ib_full set", {31'd0, ib_full}, 32'd1);
      bus_access(1, 32'hDEAD_BEEF, 0, 0);
      chk("R4 trdy_n on full write", {31'd0, g_trdy}, 32'd1);
      chk("R4 stop_n on full write", {31'd0, g_stop}, 32'd0);
      for (int i = 0; i < DEPTH; i++) addon_pop("R4 contents kept", 32'hB000_0000 + i);
      @(negedge clk);
      chk("R4 nothing stored", {31'd0, ib_rvalid}, 32'd0);
      @(negedge clk);
      chk("R7 ib_empty after drain", {31'd0, ib_empty}, 32'd1);
   endtask

   task automatic t_reads;
      addon_push(32'hC0DE_0001);
      addon_push(32'hC0DE_0002);
      bus_access(0, 32'h0, 0, 0);
      chk("R1 trdy_n on read", {31'd0, g_trdy}, 32'd0);
      chk("R1 stop_n with data", {31'd0, g_stop}, 32'd0);
      chk("R1 head word", g_data, 32'hC0DE_0001);
      bus_access(0, 32'h0, 1, 0);
      chk("R1 second word", g_data, 32'hC0DE_0002);
      chk("R7 ob_empty lags one clock", {31'd0, bo_ob_empty}, 32'd0);
      chk("R7 ob_empty follows", {31'd0, ob_empty}, 32'd1);
      bus_access(0, 32'h0, 0, 0);
      chk("R2 retry after drain", {31'd0, g_trdy}, 32'd1);
   endtask

   task automatic t_push_pop;
      bus_access(1, 32'hE000_0001, 0, 0);
      bus_access(1, 32'hE000_0002, 0, 1);
      chk("R9 write accepted", {31'd0, g_trdy}, 32'd0);
      addon_pop("R9 remaining word", 32'hE000_0002);
      @(negedge clk);
      chk("R9 occupancy one", {31'd0, ib_rvalid}, 32'd0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            @(negedge clk);
            t_reset();
            t_no_hit();
            t_empty_read();
            t_write_order();
            t_full_write();
            t_reads();
            t_push_pop();
         end
         begin
            repeat (20000) @(posedge clk);
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule